// File: doc/BRIEF.md
# Two-Lane Double-Data-Rate Sample Deserializer

This block rebuilds parallel converter samples from a serial source that spreads each 12-bit sample over two data lanes. A bit clock supplied by the source travels with the data; every rising and every falling edge of that clock presents one new bit on each lane. The bit clock runs at three times the sample rate, so one sample takes six bit slots per lane. A frame signal, also driven by the source, is high for the first half of each sample and low for the second half. Its low-to-high transition marks where a sample begins.

Inside the block, one register bank captures the lanes and the frame level on the rising edge and a second bank captures them on the falling edge. On each rising edge the two captured slots are processed in time order. A slot counter shifts the lane bits into per-lane shift registers. After six slots the two lanes are interleaved into one word. The word is presented together with a one-cycle valid strobe.

The output is a valid-only stream. The converter cannot be stalled, so there is no ready input and no back-pressure. The receiver must take every word in the cycle its valid strobe is high. The word then holds until the next strobe. If a frame transition arrives in the middle of a sample, the block discards the partial sample, restarts counting at that transition and raises a sticky error flag.

Top module: `ddr_sample_deser`

## Requirements
- R1: An active-high synchronous reset, sampled on the rising bit-clock edge, clears the slot counter, the shift registers, `word_o`, `valid_o` and `align_err_o`. `valid_o` and `align_err_o` are low in the cycle after any cycle in which reset is high.
- R2: Slots are taken in time order. The bit captured on a rising edge comes before the bit captured on the following falling edge, and every captured slot of a sample reaches the word exactly once.
- R3: `lane_i[0]` carries the odd weights 11, 9, 7, 5, 3, 1 and `lane_i[1]` carries the even weights 10, 8, 6, 4, 2, 0. On both lanes the highest weight arrives first.
- R4: A sample starts at the first slot whose captured frame level is 1 when the previous slot's level was 0. This slot may be captured on either clock edge.
- R5: `valid_o` is high for exactly one cycle per sample, and two strobes are at least three cycles apart. `word_o` does not change while `valid_o` is low.
- R6: The strobe appears on the first rising edge after the sixth slot if that slot was captured on a falling edge. It appears on the second rising edge after the sixth slot if that slot was captured on a rising edge.
- R7: Before the first frame transition after reset, and in slots outside a sample, lane data is ignored and no strobe is produced.
- R8: A frame transition that arrives while a sample is partly collected discards that partial sample and starts a new one at the transition. It also sets `align_err_o`. A sample whose frame transition comes at the expected point leaves `align_err_o` unchanged.
- R9: `align_err_o`, once set, stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Source-synchronous bit clock; both edges capture data |
| rst | input | 1 | Synchronous active-high reset |
| lane_i | input | 2 | Serial data lanes; bit 0 odd weights, bit 1 even weights |
| frame_i | input | 1 | Frame level; a rise marks the start of a sample |
| word_o | output | 12 | Assembled parallel sample |
| valid_o | output | 1 | One-cycle strobe for a new `word_o` |
| align_err_o | output | 1 | Sticky flag for a frame transition inside a sample |

## Verification
The bench sends every one of the 4096 sample values with the frame transition on a rising-edge slot. It then sends a further set of values shifted by one slot, so that each sample starts on a falling-edge slot. In both phases it checks each word and its exact arrival time. A design that swapped the order of the two capture banks, or that mixed up the lanes, would return the bits of each pair in the wrong places. A design that ignored the capture phase would deliver words a cycle early or late. The bench also cuts a sample short with an early frame transition, which must produce the error flag, no word for the partial sample and a correct word for the sample that follows. Finally it sends data while the frame is held low, where any strobe means the lanes were not being ignored.

// File: rtl/ddr_deser_pkg.sv
`timescale 1ns/1ps
package ddr_deser_pkg;
  localparam int DFLT_SAMPLE_W = 12;
  localparam int DFLT_LANE_N   = 2;
  localparam int DDR_PHASES    = 2;

  typedef enum logic {
    PH_RISE = 1'b0,
    PH_FALL = 1'b1
  } ddr_phase_e;

  function automatic int cnt_width(input int slots);
    return $clog2(slots + 1);
  endfunction
endpackage

// File: rtl/ddr_capture.sv
`timescale 1ns/1ps
module ddr_capture #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] rise_q,
  output logic [W-1:0] fall_q
);
  always_ff @(posedge clk) begin
    if (rst) rise_q <= '0;
    else     rise_q <= d;
  end

  always_ff @(negedge clk) begin
    if (rst) fall_q <= '0;
    else     fall_q <= d;
  end
endmodule

// File: rtl/ddr_slot_step.sv
`timescale 1ns/1ps
module ddr_slot_step #(
  parameter int LANE_N = 2,
  parameter int SLOTS  = 6,
  parameter int CW     = 3
) (
  input  logic [CW-1:0]           cnt_i,
  input  logic                    pf_i,
  input  logic [LANE_N*SLOTS-1:0] sh_i,
  input  logic [LANE_N-1:0]       bit_i,
  input  logic                    fr_i,
  output logic [CW-1:0]           cnt_o,
  output logic                    pf_o,
  output logic [LANE_N*SLOTS-1:0] sh_o,
  output logic                    emit_o,
  output logic                    err_o
);
  logic                    start;
  logic                    busy;
  logic [CW-1:0]           cnt_adv;
  logic [LANE_N*SLOTS-1:0] sh_shift;

  assign start = fr_i & ~pf_i;
  assign busy  = (cnt_i != '0);

  // newest bit enters at the bottom; the first bit of a sample ends at the top
  for (genvar l = 0; l < LANE_N; l++) begin : g_lane
    assign sh_shift[l*SLOTS +: SLOTS] = {sh_i[l*SLOTS +: SLOTS-1], bit_i[l]};
  end

  always_comb begin
    cnt_adv = cnt_i;
    sh_o    = sh_i;
    if (start) begin
      cnt_adv = CW'(1);
      sh_o    = sh_shift;
    end else if (busy) begin
      cnt_adv = cnt_i + 1'b1;
      sh_o    = sh_shift;
    end
    emit_o = (cnt_adv == CW'(SLOTS));
    cnt_o  = emit_o ? '0 : cnt_adv;
  end

  assign err_o = start & busy;
  assign pf_o  = fr_i;
endmodule

// File: rtl/ddr_word_pack.sv
`timescale 1ns/1ps
module ddr_word_pack #(
  parameter int LANE_N = 2,
  parameter int SLOTS  = 6
) (
  input  logic [LANE_N*SLOTS-1:0] sh_i,
  output logic [LANE_N*SLOTS-1:0] word_o
);
  // lane l holds weights congruent to LANE_N-1-l; shift position s is weight group s
  for (genvar l = 0; l < LANE_N; l++) begin : g_lane
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      assign word_o[s*LANE_N + (LANE_N-1-l)] = sh_i[l*SLOTS + s];
    end
  end
endmodule

// File: rtl/ddr_sample_deser.sv
`timescale 1ns/1ps
module ddr_sample_deser
  import ddr_deser_pkg::*;
#(
  parameter int SAMPLE_W = DFLT_SAMPLE_W,
  parameter int LANE_N   = DFLT_LANE_N
) (
  input  logic                clk_bit,
  input  logic                rst,
  input  logic [LANE_N-1:0]   lane_i,
  input  logic                frame_i,
  output logic [SAMPLE_W-1:0] word_o,
  output logic                valid_o,
  output logic                align_err_o
);
  localparam int SLOTS = SAMPLE_W / LANE_N;
  localparam int CW    = cnt_width(SLOTS);
  localparam int CAP_W = LANE_N + 1;
  localparam int SH_W  = LANE_N * SLOTS;

  logic [CAP_W-1:0] rise_q, fall_q;
  logic [CAP_W-1:0] slot_in [DDR_PHASES];

  logic [CW-1:0]   cnt_q;
  logic            pf_q;
  logic [SH_W-1:0] sh_q;

  logic [CW-1:0]   cnt_c [DDR_PHASES+1];
  logic            pf_c  [DDR_PHASES+1];
  logic [SH_W-1:0] sh_c  [DDR_PHASES+1];
  logic [DDR_PHASES-1:0] emit_v, err_v;

  logic [SH_W-1:0]     sel_sh;
  logic [SAMPLE_W-1:0] packed_w;

  ddr_capture #(.W(CAP_W)) u_cap (
    .clk    (clk_bit),
    .rst    (rst),
    .d      ({frame_i, lane_i}),
    .rise_q (rise_q),
    .fall_q (fall_q)
  );

  // rise_q still holds the earlier rising-edge slot; fall_q the slot after it
  assign slot_in[PH_RISE] = rise_q;
  assign slot_in[PH_FALL] = fall_q;

  assign cnt_c[0] = cnt_q;
  assign pf_c[0]  = pf_q;
  assign sh_c[0]  = sh_q;

  for (genvar p = 0; p < DDR_PHASES; p++) begin : g_phase
    ddr_slot_step #(.LANE_N(LANE_N), .SLOTS(SLOTS), .CW(CW)) u_step (
      .cnt_i  (cnt_c[p]),
      .pf_i   (pf_c[p]),
      .sh_i   (sh_c[p]),
      .bit_i  (slot_in[p][LANE_N-1:0]),
      .fr_i   (slot_in[p][LANE_N]),
      .cnt_o  (cnt_c[p+1]),
      .pf_o   (pf_c[p+1]),
      .sh_o   (sh_c[p+1]),
      .emit_o (emit_v[p]),
      .err_o  (err_v[p])
    );
  end

  always_comb begin
    sel_sh = '0;
    for (int p = 0; p < DDR_PHASES; p++) begin
      if (emit_v[p]) sel_sh = sh_c[p+1];
    end
  end

  ddr_word_pack #(.LANE_N(LANE_N), .SLOTS(SLOTS)) u_pack (
    .sh_i   (sel_sh),
    .word_o (packed_w)
  );

  always_ff @(posedge clk_bit) begin
    if (rst) begin
      cnt_q       <= '0;
      pf_q        <= 1'b0;
      sh_q        <= '0;
      valid_o     <= 1'b0;
      word_o      <= '0;
      align_err_o <= 1'b0;
    end else begin
      cnt_q   <= cnt_c[DDR_PHASES];
      pf_q    <= pf_c[DDR_PHASES];
      sh_q    <= sh_c[DDR_PHASES];
      valid_o <= |emit_v;
      if (|emit_v) word_o <= packed_w;
      if (|err_v)  align_err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/ddr_sample_deser_chk.sv
`timescale 1ns/1ps
module ddr_sample_deser_chk #(
  parameter int SAMPLE_W = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                frame_i,
  input logic [SAMPLE_W-1:0] word_o,
  input logic                valid_o,
  input logic                align_err_o
);
  logic seen_hi;

  always_ff @(posedge clk) begin
    if (rst)          seen_hi <= 1'b0;
    else if (frame_i) seen_hi <= 1'b1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!valid_o && !align_err_o));

  assert_valid_gap_R5: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (!$past(valid_o) && !$past(valid_o, 2)));

  assert_word_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!valid_o && !$past(rst)) |-> $stable(word_o));

  assert_no_early_valid_R7: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> seen_hi);

  assert_err_no_emit_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(align_err_o) |-> !valid_o);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(align_err_o)) |-> align_err_o);
endmodule

bind ddr_sample_deser ddr_sample_deser_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk         (clk_bit),
  .rst         (rst),
  .frame_i     (frame_i),
  .word_o      (word_o),
  .valid_o     (valid_o),
  .align_err_o (align_err_o)
);

// File: tb/test_ddr_sample_deser.sv
`timescale 1ns/1ps
module test_ddr_sample_deser;
  logic        clk_bit;
  logic        rst;
  logic [1:0]  lane_i;
  logic        frame_i;
  logic [11:0] word_o;
  logic        valid_o;
  logic        align_err_o;

  int total = 0;
  int bad   = 0;
  longint slot_idx = 0;
  longint cyc = 0;
  longint last_valid_cyc = -1;
  logic [11:0] last_word = '0;
  bit had_valid = 0;
  bit done = 0;

  logic [11:0] exp_w[$];
  longint      exp_t[$];
  string       exp_tag[$];

  ddr_sample_deser i_ddr_sample_deser (
    .clk_bit     (clk_bit),
    .rst         (rst),
    .lane_i      (lane_i),
    .frame_i     (frame_i),
    .word_o      (word_o),
    .valid_o     (valid_o),
    .align_err_o (align_err_o)
  );

  initial clk_bit = 1'b0;
  always #2 clk_bit = ~clk_bit;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one slot per call, 2 ns each, data changes midway between clock edges
  task automatic drive_slot(input logic a, input logic b, input logic f);
    lane_i  = {b, a};
    frame_i = f;
    slot_idx++;
    #2;
  endtask

  task automatic send_frame(input logic [11:0] w, input string tag);
    for (int i = 0; i < 6; i++) begin
      if (i == 5) begin
        exp_w.push_back(w);
        exp_t.push_back($time + ((slot_idx % 2 == 1) ? 4 : 6));
        exp_tag.push_back(tag);
      end
      drive_slot(w[11-2*i], w[10-2*i], i < 3);
    end
  endtask

  always @(posedge clk_bit) begin
    cyc++;
    #1;
    if (rst) begin
      had_valid = 0;
      last_valid_cyc = -1;
    end else if (valid_o) begin
      if (exp_w.size() == 0) begin
        check(0, "R7 unexpected valid", longint'(word_o), 0);
      end else begin
        logic [11:0] w;
        longint t;
        string tg;
        w  = exp_w.pop_front();
        t  = exp_t.pop_front();
        tg = exp_tag.pop_front();
        check(word_o == w, tg, longint'(word_o), longint'(w));
        check($time == t, "R6 strobe time", longint'($time), t);
      end
      if (last_valid_cyc >= 0)
        check(cyc - last_valid_cyc >= 3, "R5 strobe gap", cyc - last_valid_cyc, 3);
      last_valid_cyc = cyc;
      last_word = word_o;
      had_valid = 1;
    end else if (had_valid) begin
      check(word_o == last_word, "R5 word hold", longint'(word_o), longint'(last_word));
    end
  end

  initial begin
    #400000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    lane_i = '0;
    frame_i = 1'b0;
    #1;
    repeat (8) drive_slot(1'b1, 1'b1, 1'b0);
    rst = 1'b0;
    check(valid_o == 1'b0, "R1 valid after reset", valid_o, 0);
    check(align_err_o == 1'b0, "R1 err after reset", align_err_o, 0);
    check(word_o == '0, "R1 word after reset", longint'(word_o), 0);

    // R7: lane activity with frame low produces nothing
    for (int i = 0; i < 10; i++) drive_slot(i[0], ~i[0], 1'b0);

    // R2 R3: all values, sample starts on rising-edge slots
    for (int w = 0; w < 4096; w++) send_frame(12'(w), "R3 word even phase");
    check(align_err_o == 1'b0, "R8 no error on aligned frames", align_err_o, 0);

    // R4: one extra idle slot shifts starts onto falling-edge slots
    drive_slot(1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 256; k++) send_frame(12'((k * 37 + 11) & 12'hFFF), "R4 word odd phase");
    check(align_err_o == 1'b0, "R8 no error after phase shift", align_err_o, 0);

    // R8: four slots of a sample, then an early frame transition
    drive_slot(1'b1, 1'b1, 1'b1);
    drive_slot(1'b0, 1'b1, 1'b1);
    drive_slot(1'b1, 1'b0, 1'b1);
    drive_slot(1'b1, 1'b1, 1'b0);
    send_frame(12'hA5C, "R8 word after resync");
    repeat (3) drive_slot(1'b0, 1'b0, 1'b0);
    check(align_err_o == 1'b1, "R8 error on early transition", align_err_o, 1);

    // R9: clean samples leave the flag set
    for (int k = 0; k < 3; k++) send_frame(12'(k * 1000 + 7), "R9 word with flag set");
    repeat (4) drive_slot(1'b0, 1'b0, 1'b0);
    check(align_err_o == 1'b1, "R9 error stays set", align_err_o, 1);

    rst = 1'b1;
    repeat (4) drive_slot(1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    repeat (2) drive_slot(1'b0, 1'b0, 1'b0);
    check(align_err_o == 1'b0, "R9 error cleared by reset", align_err_o, 0);
    check(valid_o == 1'b0, "R1 valid low after second reset", valid_o, 0);

    send_frame(12'h5A3, "R3 word after reset");
    repeat (8) drive_slot(1'b0, 1'b0, 1'b0);
    check(exp_w.size() == 0, "R2 all samples delivered", exp_w.size(), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule